// File: doc/BRIEF.md
# Return Address Stack With Repair

This block holds predicted return addresses for a speculative fetch unit. When fetch predicts a call, the call's return address is pushed onto a circular stack. When fetch predicts a return, the entry on top of the stack is the predicted target, and the stack is then popped. Before popping, fetch keeps the current top index and top entry as a checkpoint.

When speculation turns out to be wrong, the pipeline repairs the stack. A squashed return that used the stack is undone through the restore port. The restore port moves the top pointer back to the saved index and rewrites that entry with the saved value. A squashed call that pushed an entry is undone with one pop. The `empty_o` flag tells fetch that a return must be predicted not taken, and that `top_data_o` is not to be used as its target.

The stack accepts a command in every cycle. None of its inputs can be refused, so there is no back-pressure. The caller must not present a push or pop that it cannot afford to lose. The depth is `DEPTH` entries, which must be a power of two (16 by default). The address width is `DW`.

Top module: `ras_repair`

## Requirements
- R1: After reset `empty_o` is 1, `top_idx_o` is DEPTH-1 and every entry, including `top_data_o`, is zero.
- R2: A push alone (no pop, no restore) moves the top index to (index+1) mod DEPTH. It writes `push_addr_i` into that slot, and the new value shows on `top_data_o` in the next cycle.
- R3: A pop alone on a non-empty stack moves the top index to (index-1) mod DEPTH. `top_data_o` then shows the entry that was pushed before the popped one.
- R4: A pop alone on an empty stack leaves the top index, the stored entries and `empty_o` unchanged.
- R5: A push on a full stack (DEPTH entries held) overwrites the oldest entry, and occupancy stays at DEPTH.
- R6: A restore sets the top index to `restore_idx_i` and writes `restore_data_i` into that slot. It also raises occupancy by one, saturating at DEPTH, so `empty_o` is 0 afterwards.
- R7: A restore has priority. A push or pop asserted in the same cycle is ignored.
- R8: A push and a pop together, without a restore, replace the top entry with `push_addr_i`. The index does not move, and an empty stack becomes non-empty with occupancy 1.
- R9: `empty_o` is 1 exactly when occupancy is zero. Occupancy saturates at 0 and at DEPTH, so DEPTH pops after any number of pushes leave the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push `push_addr_i` (predicted call) |
| push_addr_i | input | DW | Return address to push |
| pop_i | input | 1 | Pop one entry (predicted return, or undo of a squashed call) |
| restore_i | input | 1 | Repair from a checkpoint |
| restore_idx_i | input | $clog2(DEPTH) | Saved top index |
| restore_data_i | input | DW | Saved top entry |
| top_data_o | output | DW | Entry at the top index (predicted return target) |
| top_idx_o | output | $clog2(DEPTH) | Current top index (checkpoint value) |
| empty_o | output | 1 | Stack holds no valid entry |

## Verification
The bench pushes past full so that the pointer wraps and the oldest entries are overwritten. It then pops past empty. A design without saturating occupancy would report non-empty after the wrap, or would move its pointer on an empty pop. Every index gets a restore, and restores are given together with pushes and pops. A design with the wrong priority would show a moved index or the wrong data. A checkpoint is also taken, the saved slot is overwritten by a later push, and the checkpoint is then restored. A repair that only moved the pointer would return the overwritten value. Simultaneous push and pop, on an empty stack and on a populated one, catch a design that treats the pair as two separate moves.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_REPLACE = 3'd3,
    OP_RESTORE = 3'd4
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop,
                                        input logic restore);
    if (restore)          return OP_RESTORE;
    else if (push && pop) return OP_REPLACE;
    else if (push)        return OP_PUSH;
    else if (pop)         return OP_POP;
    else                  return OP_IDLE;
  endfunction
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op,
  input  logic [AW-1:0] restore_idx,
  output logic [AW-1:0] tos,
  output logic          empty,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] occ, occ_n;
  logic [AW-1:0] tos_n;
  logic [CW-1:0] occ_inc;

  // occupancy plus one, held at the depth
  assign occ_inc = (occ == FULL) ? FULL : occ + 1'b1;

  always_comb begin
    tos_n  = tos;
    occ_n  = occ;
    wr_en  = 1'b0;
    wr_idx = tos;
    unique case (op)
      OP_PUSH: begin
        tos_n  = tos + 1'b1;
        wr_en  = 1'b1;
        wr_idx = tos + 1'b1;
        occ_n  = occ_inc;
      end
      OP_POP: begin
        if (occ != '0) begin
          tos_n = tos - 1'b1;
          occ_n = occ - 1'b1;
        end
      end
      OP_REPLACE: begin
        wr_en = 1'b1;
        if (occ == '0) occ_n = CW'(1);
      end
      OP_RESTORE: begin
        tos_n  = restore_idx;
        wr_en  = 1'b1;
        wr_idx = restore_idx;
        occ_n  = occ_inc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos <= '1;
      occ <= '0;
    end else begin
      tos <= tos_n;
      occ <= occ_n;
    end
  end

  assign empty = (occ == '0);
endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (wr_en) begin
      slot[wr_idx] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/ras_repair.sv
module ras_repair
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_addr_i,
  input  logic          pop_i,
  input  logic          restore_i,
  input  logic [AW-1:0] restore_idx_i,
  input  logic [DW-1:0] restore_data_i,
  output logic [DW-1:0] top_data_o,
  output logic [AW-1:0] top_idx_o,
  output logic          empty_o
);
  stk_op_e       op;
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_data;

  assign op      = decode_op(push_i, pop_i, restore_i);
  assign wr_data = (op == OP_RESTORE) ? restore_data_i : push_addr_i;

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .restore_idx (restore_idx_i),
    .tos         (top_idx_o),
    .empty       (empty_o),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx)
  );

  ras_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (top_idx_o),
    .rd_data (top_data_o)
  );
endmodule

// File: rtl/ras_repair_chk.sv
module ras_repair_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic [DW-1:0] push_addr_i,
  input logic          pop_i,
  input logic          restore_i,
  input logic [AW-1:0] restore_idx_i,
  input logic [DW-1:0] restore_data_i,
  input logic [DW-1:0] top_data_o,
  input logic [AW-1:0] top_idx_o,
  input logic          empty_o
);
  // R2
  push_moves_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !restore_i) |=>
      (top_idx_o == AW'($past(top_idx_o) + 1'b1)) && (top_data_o == $past(push_addr_i)) && !empty_o);

  // R3
  pop_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !restore_i && !empty_o) |=>
      (top_idx_o == AW'($past(top_idx_o) - 1'b1)));

  // R4
  empty_pop_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !restore_i && empty_o) |=>
      $stable(top_idx_o) && $stable(top_data_o) && empty_o);

  // R6
  restore_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=>
      (top_idx_o == $past(restore_idx_i)) && (top_data_o == $past(restore_data_i)) && !empty_o);

  // R8
  replace_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !restore_i) |=>
      $stable(top_idx_o) && (top_data_o == $past(push_addr_i)) && !empty_o);
endmodule

bind ras_repair ras_repair_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .push_i         (push_i),
  .push_addr_i    (push_addr_i),
  .pop_i          (pop_i),
  .restore_i      (restore_i),
  .restore_idx_i  (restore_idx_i),
  .restore_data_i (restore_data_i),
  .top_data_o     (top_data_o),
  .top_idx_o      (top_idx_o),
  .empty_o        (empty_o)
);

// File: tb/sim_ras_repair.sv
`timescale 1ns/1ps
module sim_ras_repair;
  localparam int D  = 16;
  localparam int DW = 32;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0, restore_i = 1'b0;
  logic [DW-1:0] push_addr_i = '0, restore_data_i = '0;
  logic [AW-1:0] restore_idx_i = '0;
  logic [DW-1:0] top_data_o;
  logic [AW-1:0] top_idx_o;
  logic          empty_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // expected state, worked out from the requirements
  logic [DW-1:0] m [D];
  int tos, cnt;

  always #2.5 clk = ~clk;

  ras_repair #(.DEPTH(D), .DW(DW)) u0 (.*);

  task automatic check(string req);
    n_cmp++;
    if (top_idx_o !== AW'(tos) || top_data_o !== m[tos] || empty_o !== (cnt == 0)) begin
      n_bad++;
      $display("FAIL %s: idx=%0d data=%h empty=%0b expected idx=%0d data=%h empty=%0b",
               req, top_idx_o, top_data_o, empty_o, tos, m[tos], cnt == 0);
    end
  endtask

  task automatic step(string req, bit p, bit q, bit r, logic [DW-1:0] a,
                      int ridx, logic [DW-1:0] rd);
    @(negedge clk);
    push_i = p; pop_i = q; restore_i = r;
    push_addr_i = a; restore_idx_i = AW'(ridx); restore_data_i = rd;
    if (r) begin
      tos = ridx; m[ridx] = rd; cnt = (cnt < D) ? cnt + 1 : D;
    end else if (p && q) begin
      m[tos] = a; if (cnt == 0) cnt = 1;
    end else if (p) begin
      tos = (tos + 1) % D; m[tos] = a; cnt = (cnt < D) ? cnt + 1 : D;
    end else if (q) begin
      if (cnt > 0) begin tos = (tos + D - 1) % D; cnt--; end
    end
    @(posedge clk); #1;
    check(req);
    push_i = 0; pop_i = 0; restore_i = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    int sidx;
    logic [DW-1:0] sval;
    for (int i = 0; i < D; i++) m[i] = '0;
    tos = D - 1; cnt = 0;
    #12; check("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; check("R1 after release");

    // R4: pops on an empty stack
    for (int i = 0; i < 3; i++) step("R4 empty pop", 0, 1, 0, '0, 0, '0);

    // R2 then R5: fill past full so the pointer wraps
    for (int i = 0; i < D + 4; i++)
      step(i < D ? "R2 push" : "R5 overflow push", 1, 0, 0, 32'h1000 + 32'(i * 4), 0, '0);

    // R3 then R9: drain, then keep popping
    for (int i = 0; i < D + 2; i++)
      step(i < D ? "R3 pop" : "R9 saturated empty", 0, 1, 0, '0, 0, '0);

    // R8: push+pop on empty, then on a populated stack
    step("R8 replace empty", 1, 1, 0, 32'hAAAA_0001, 0, '0);
    step("R2 push", 1, 0, 0, 32'hAAAA_0002, 0, '0);
    step("R8 replace top", 1, 1, 0, 32'hAAAA_0003, 0, '0);
    step("R3 pop", 0, 1, 0, '0, 0, '0);

    // R6: restore at every index
    for (int i = 0; i < D; i++)
      step("R6 restore sweep", 0, 0, 1, '0, i, 32'hC000_0000 + 32'(i));

    // R7: restore wins over push, pop and both
    step("R7 restore vs push", 1, 0, 1, 32'hDEAD_0001, 3, 32'hBEEF_0003);
    step("R7 restore vs pop", 0, 1, 1, 32'hDEAD_0002, 9, 32'hBEEF_0009);
    step("R7 restore vs both", 1, 1, 1, 32'hDEAD_0003, 14, 32'hBEEF_000E);

    // R6: checkpoint, speculative pop, wrong-path push overwrites slot, repair
    step("R2 push", 1, 0, 0, 32'h5555_0001, 0, '0);
    step("R2 push", 1, 0, 0, 32'h5555_0002, 0, '0);
    sidx = tos; sval = m[tos];
    step("R3 speculative pop", 0, 1, 0, '0, 0, '0);
    step("R2 wrong-path push", 1, 0, 0, 32'h6666_0000, 0, '0);
    step("R6 repair", 0, 0, 1, '0, sidx, sval);
    step("R3 pop after repair", 0, 1, 0, '0, 0, '0);

    summary();
  end
endmodule